// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer with Interval Refresh

This block sits between a simple word-wide request port and one asynchronous page-mode DRAM device. A requester offers a read or write with a valid/ready handshake and a linear word address. The block splits the address into row and column and drives the row/column strobes, the write and output enables, and the shared address bus. Read words come back with a single-cycle valid pulse, in the order the requests were taken.

Once a row is opened, it stays open. Later requests to the same row cost only a column strobe pulse. A request to another row first closes the open row and waits out the row precharge time. A free-running timer schedules refresh cycles at a fixed interval. In these cycles the column strobe falls before the row strobe, so the device picks the row from its own counter. A due refresh beats any new request.

Writes always assert the write enable before the column strobe falls, so the device never drives the bus during a write. Reads take the data one clock after the column strobe has risen again. This relies on the extended-data-out hold of the device. All four timing gaps are parameters counted in clock cycles, and each must be at least 1.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, `dram_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: A request to a closed row drives the row on `dram_addr` when `dram_ras_n` falls. It drives the column when `dram_cas_n` falls, and that fall comes at least `T_RCD` cycles later.
- R3: A request to the open row is served by a column strobe pulse alone, with `dram_ras_n` held low. Each `dram_cas_n` low time is at least `T_CAS` cycles, and each high time before a new fall is at least `T_CP` cycles.
- R4: A request to a row other than the open one is not accepted at once. `dram_ras_n` rises first, and the next fall of `dram_ras_n` comes at least `T_RP` cycles after the rise.
- R5: For a write, `dram_we_n` is low at least one cycle before `dram_cas_n` falls. During the write, `dram_oe_n` is high and `dram_dq_oe` is 1, with the write word on `dram_dq_out`. `dram_dq_oe` is never 1 while `dram_we_n` is high.
- R6: For a read, `dram_we_n` stays high and `dram_oe_n` is low. `dram_dq_in` is captured at the clock edge one cycle after `dram_cas_n` rises. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R7: A refresh drops `dram_cas_n` while `dram_ras_n` is high, then drops `dram_ras_n` at least one cycle later with `dram_we_n` high. Both strobes rise together no sooner than `T_RCD+T_CAS` cycles after the row strobe fell.
- R8: A refresh falls due every `REF_INTERVAL` cycles. While one is due, no request is accepted, and an open row is closed first. Consecutive refreshes are therefore spaced by at most `REF_INTERVAL` plus one access and one precharge.
- R9: Row = `req_addr[ADDR_W-1:COL_W]` and column = `req_addr[COL_W-1:0]`. Both are zero-extended onto `dram_addr`.
- R10: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. Every read taken yields exactly one response, in request order, with the most recently written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Linear word address |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | Read word valid (one cycle) |
| rsp_rdata | output | DATA_W | Read word |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Data driven toward the device |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W | Data returned by the device |

## Verification
The bench builds the block with a 4-bit row, a 3-bit column and a 16-bit word. The timing values are `T_RCD=3`, `T_CAS=2`, `T_CP=2`, `T_RP=3`, and refresh falls due every 60 cycles. With so few rows and columns, page hits, page misses and repeated writes to the same word all occur within short request streams. With the short interval, refreshes land in the middle of open pages and in-flight traffic many times, so the close-before-refresh path and the refresh spacing bound are both exercised. Timing values above one cycle show whether each gap is counted from the right edge.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_CLOSED,
        ST_RCD,
        ST_COL,
        ST_CAS,
        ST_CP,
        ST_OPEN,
        ST_REF_CAS,
        ST_REF_RAS
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    function automatic int fpm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int fpm_cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer
    import fpm_pkg::*;
#(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pending
);
    localparam int CNT_W = fpm_cnt_w(INTERVAL);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             tick;

    assign tick    = (cnt_q == LAST);
    assign pending = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= tick ? '0 : cnt_q + 1'b1;
            pend_q <= tick | (pend_q & ~ack);
        end
    end

    // R8: a due refresh stays due until the sequencer takes it
    a_r8_pending_held: assert property (@(posedge clk) disable iff (rst)
        pend_q && !ack |=> pend_q);

endmodule

// File: rtl/fpm_row_tracker.sv
module fpm_row_tracker #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_set,
    input  logic             open_clr,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] req_row,
    output logic             open_valid,
    output logic             hit
);
    logic             valid_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            row_q   <= '0;
        end else if (open_clr) begin
            valid_q <= 1'b0;
        end else if (open_set) begin
            valid_q <= 1'b1;
            row_q   <= set_row;
        end
    end

    assign open_valid = valid_q;
    assign hit        = valid_q && (req_row == row_q);

    // R3: the stored open row does not change while the page stays open
    a_r3_row_stable: assert property (@(posedge clk) disable iff (rst)
        valid_q && !open_clr |=> $stable(row_q));

endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int ROW_W  = 11,
    parameter int COL_W  = 10,
    parameter int DATA_W = 72,
    parameter int T_RCD  = 3,
    parameter int T_CAS  = 2,
    parameter int T_CP   = 1,
    parameter int T_RP   = 3,
    localparam int DA_W  = fpm_max(ROW_W, COL_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              hit,
    input  logic              open_valid,
    output logic              row_open,
    output logic              row_close,
    input  logic              ref_pending,
    output logic              ref_ack,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [DA_W-1:0]   addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int WT_W = fpm_cnt_w(fpm_max(fpm_max(T_RCD + T_CAS, T_CP), T_RP));
    localparam logic [WT_W-1:0] W_RCD = WT_W'((T_RCD > 2) ? T_RCD - 2 : 0);
    localparam logic [WT_W-1:0] W_CAS = WT_W'(T_CAS - 1);
    localparam logic [WT_W-1:0] W_CP  = WT_W'(T_CP - 1);
    localparam logic [WT_W-1:0] W_RP  = WT_W'(T_RP - 1);
    localparam logic [WT_W-1:0] W_REF = WT_W'(T_RCD + T_CAS - 1);

    seq_state_e        state_q;
    strobe_t           strb_q;
    logic [DA_W-1:0]   addr_q;
    logic [DATA_W-1:0] dq_q;
    logic              dq_oe_q;
    logic [WT_W-1:0]   wait_q;
    logic [WT_W-1:0]   rp_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_q;
    logic              sample_q;
    logic              rsp_v_q;
    logic [DATA_W-1:0] rsp_d_q;

    logic can_start, can_page, accept;

    always_comb begin
        can_start = (state_q == ST_CLOSED) && (rp_q == '0) && !ref_pending;
        can_page  = (state_q == ST_OPEN) && !ref_pending && hit;
        req_ready = can_start || can_page;
        accept    = req_valid && req_ready;
        row_open  = accept && (state_q == ST_CLOSED);
        row_close = (state_q == ST_OPEN) && (ref_pending || (req_valid && !hit));
        ref_ack   = (state_q == ST_CLOSED) && (rp_q == '0) && ref_pending;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_CLOSED;
            strb_q   <= STROBE_IDLE;
            addr_q   <= '0;
            dq_q     <= '0;
            dq_oe_q  <= 1'b0;
            wait_q   <= '0;
            rp_q     <= '0;
            col_q    <= '0;
            wr_q     <= 1'b0;
            sample_q <= 1'b0;
            rsp_v_q  <= 1'b0;
            rsp_d_q  <= '0;
        end else begin
            rsp_v_q  <= 1'b0;
            sample_q <= 1'b0;
            if (sample_q) begin
                rsp_v_q     <= 1'b1;
                rsp_d_q     <= dq_in;
                strb_q.oe_n <= 1'b1;
            end
            if (rp_q != '0) rp_q <= rp_q - 1'b1;

            unique case (state_q)
                ST_CLOSED: begin
                    if (ref_ack) begin
                        strb_q.cas_n <= 1'b0;
                        state_q      <= ST_REF_CAS;
                    end else if (accept) begin
                        strb_q.ras_n <= 1'b0;
                        strb_q.we_n  <= !req_we;
                        strb_q.oe_n  <= req_we;
                        addr_q       <= DA_W'(req_row);
                        col_q        <= req_col;
                        wr_q         <= req_we;
                        dq_q         <= req_wdata;
                        dq_oe_q      <= req_we;
                        wait_q       <= W_RCD;
                        state_q      <= ST_RCD;
                    end
                end
                ST_RCD: begin
                    if (wait_q == '0) begin
                        addr_q  <= DA_W'(col_q);
                        state_q <= ST_COL;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                ST_COL: begin
                    strb_q.cas_n <= 1'b0;
                    wait_q       <= W_CAS;
                    state_q      <= ST_CAS;
                end
                ST_CAS: begin
                    if (wait_q == '0) begin
                        strb_q.cas_n <= 1'b1;
                        strb_q.we_n  <= 1'b1;
                        dq_oe_q      <= 1'b0;
                        sample_q     <= !wr_q;
                        wait_q       <= W_CP;
                        state_q      <= ST_CP;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                ST_CP: begin
                    if (wait_q == '0) state_q <= ST_OPEN;
                    else              wait_q  <= wait_q - 1'b1;
                end
                ST_OPEN: begin
                    if (row_close) begin
                        strb_q.ras_n <= 1'b1;
                        rp_q         <= W_RP;
                        state_q      <= ST_CLOSED;
                    end else if (accept) begin
                        strb_q.we_n <= !req_we;
                        strb_q.oe_n <= req_we;
                        addr_q      <= DA_W'(req_col);
                        wr_q        <= req_we;
                        dq_q        <= req_wdata;
                        dq_oe_q     <= req_we;
                        state_q     <= ST_COL;
                    end
                end
                ST_REF_CAS: begin
                    strb_q.ras_n <= 1'b0;
                    wait_q       <= W_REF;
                    state_q      <= ST_REF_RAS;
                end
                ST_REF_RAS: begin
                    if (wait_q == '0) begin
                        strb_q.ras_n <= 1'b1;
                        strb_q.cas_n <= 1'b1;
                        rp_q         <= W_RP;
                        state_q      <= ST_CLOSED;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                default: state_q <= ST_CLOSED;
            endcase
        end
    end

    assign ras_n     = strb_q.ras_n;
    assign cas_n     = strb_q.cas_n;
    assign we_n      = strb_q.we_n;
    assign oe_n      = strb_q.oe_n;
    assign addr      = addr_q;
    assign dq_out    = dq_q;
    assign dq_oe     = dq_oe_q;
    assign rsp_valid = rsp_v_q;
    assign rsp_rdata = rsp_d_q;

    // R5: a write's enable is already low on the cycle before its column strobe falls
    a_r5_early_write: assert property (@(posedge clk) disable iff (rst)
        $fell(strb_q.cas_n) && !strb_q.ras_n && !strb_q.we_n |-> !$past(strb_q.we_n));
    // R5: output enable is off for the whole write
    a_r5_oe_off_in_write: assert property (@(posedge clk) disable iff (rst)
        !strb_q.we_n |-> strb_q.oe_n);
    // R5: bus driven only during a write
    a_r5_drive_only_write: assert property (@(posedge clk) disable iff (rst)
        dq_oe_q |-> !strb_q.we_n);
    // R6: read response lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_v_q |=> !rsp_v_q);
    // R7: in a refresh the column strobe was already low before the row strobe fell
    a_r7_cas_first: assert property (@(posedge clk) disable iff (rst)
        $fell(strb_q.ras_n) && !strb_q.cas_n |-> !$past(strb_q.cas_n));
    // R7: a refresh column strobe only happens when the timer asked for it
    a_r7_refresh_requested: assert property (@(posedge clk) disable iff (rst)
        $fell(strb_q.cas_n) && strb_q.ras_n |-> $past(ref_pending));
    // R2: the two strobes never fall on the same edge
    a_r2_no_joint_fall: assert property (@(posedge clk) disable iff (rst)
        !($fell(strb_q.ras_n) && $fell(strb_q.cas_n)));
    // R3: a page hit is only served with a row recorded as open
    a_r3_page_needs_row: assert property (@(posedge clk) disable iff (rst)
        can_page |-> open_valid && !strb_q.ras_n);

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W        = 11,
    parameter int COL_W        = 10,
    parameter int DATA_W       = 72,
    parameter int T_RCD        = 3,
    parameter int T_CAS        = 2,
    parameter int T_CP         = 1,
    parameter int T_RP         = 3,
    parameter int REF_INTERVAL = 780,
    localparam int ADDR_W      = ROW_W + COL_W,
    localparam int DA_W        = fpm_max(ROW_W, COL_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DA_W-1:0]   dram_addr,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic hit, open_valid, row_open, row_close, ref_pending, ref_ack;

    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    fpm_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    fpm_row_tracker #(.ROW_W(ROW_W)) u_rows (
        .clk        (clk),
        .rst        (rst),
        .open_set   (row_open),
        .open_clr   (row_close),
        .set_row    (req_row),
        .req_row    (req_row),
        .open_valid (open_valid),
        .hit        (hit)
    );

    fpm_seq #(
        .ROW_W (ROW_W), .COL_W (COL_W), .DATA_W (DATA_W),
        .T_RCD (T_RCD), .T_CAS (T_CAS), .T_CP (T_CP), .T_RP (T_RP)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_we      (req_we),
        .req_row     (req_row),
        .req_col     (req_col),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .hit         (hit),
        .open_valid  (open_valid),
        .row_open    (row_open),
        .row_close   (row_close),
        .ref_pending (ref_pending),
        .ref_ack     (ref_ack),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n),
        .we_n        (dram_we_n),
        .oe_n        (dram_oe_n),
        .addr        (dram_addr),
        .dq_out      (dram_dq_out),
        .dq_oe       (dram_dq_oe),
        .dq_in       (dram_dq_in),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

    // R8: nothing is taken from the requester while a refresh is owed
    a_r8_no_accept_when_due: assert property (@(posedge clk) disable iff (rst)
        ref_pending && req_valid |=> !$rose(dram_cas_n) || dram_ras_n || !$past(req_ready));

endmodule

// File: tb/fpm_dram_ctrl_test.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_test;
    localparam int ROW_W = 4, COL_W = 3, DW = 16;
    localparam int T_RCD = 3, T_CAS = 2, T_CP = 2, T_RP = 3;
    localparam int REF_IV = 60, SLACK = 30;
    localparam int AW = ROW_W + COL_W;
    localparam int DAW = (ROW_W > COL_W) ? ROW_W : COL_W;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [DW-1:0] rsp_rdata, dq_out;
    logic [DW-1:0] dq_in;
    logic [DAW-1:0] dram_addr;

    fpm_dram_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
        .T_CP(T_CP), .T_RP(T_RP), .REF_INTERVAL(REF_IV)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
        .dram_addr(dram_addr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe),
        .dram_dq_in(dq_in)
    );

    always #4 clk = ~clk;

    int vectors = 0, fails = 0, cycles = 0;
    bit done = 0, run_model = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            vectors++; fails++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // behavioural device, reference memory and protocol model
    logic [DW-1:0] dev_mem [int];
    logic [DW-1:0] ref_mem [int];
    logic [DW-1:0] exp_q [$];
    int cur_addr = 0;
    int p_ras = 1, p_cas = 1, p_we = 1;
    int since_ras_rise = 1000, since_ras_fall = 0, since_cas_rise = 1000;
    int since_cas_fall = 0, since_ref = 0;
    int acc_ras_falls = 0, ras_rises = 0, refreshes = 0, responses = 0;
    int row_lat = 0;
    bit drv_on = 0;
    logic [DW-1:0] drv_data = '0;

    assign dq_in = drv_on ? drv_data : '1;

    always @(negedge clk) begin
        if (run_model) begin
            since_ras_rise++; since_ras_fall++; since_cas_rise++; since_cas_fall++; since_ref++;
            // R5 each cycle: bus driven only for writes
            chk(!(dq_oe && we_n), "R5 drive without write", dq_oe, 0);
            if (drv_on && (ras_n || oe_n)) drv_on = 0;
            if (p_ras == 1 && ras_n == 0) begin
                if (cas_n == 0) begin
                    chk(we_n == 1, "R7 refresh write enable high", we_n, 1);
                    chk(p_cas == 0, "R7 column strobe first", p_cas, 0);
                    chk(since_ref <= REF_IV + SLACK, "R8 refresh spacing", since_ref, REF_IV + SLACK);
                    refreshes++; since_ref = 0;
                end else begin
                    chk(since_ras_rise >= T_RP, "R4 row precharge", since_ras_rise, T_RP);
                    chk(dram_addr == DAW'(cur_addr >> COL_W), "R9 row address", dram_addr, cur_addr >> COL_W);
                    row_lat = dram_addr; acc_ras_falls++;
                end
                since_ras_fall = 0;
            end
            if (p_ras == 0 && ras_n == 1) begin
                if (cas_n == 1 && p_cas == 0)
                    chk(since_ras_fall >= T_RCD + T_CAS, "R7 refresh row low time", since_ras_fall, T_RCD + T_CAS);
                since_ras_rise = 0; ras_rises++;
            end
            if (p_cas == 1 && cas_n == 0) begin
                if (ras_n == 0) begin
                    chk(since_ras_fall >= T_RCD, "R2 row to column delay", since_ras_fall, T_RCD);
                    chk(since_cas_rise >= T_CP, "R3 column precharge", since_cas_rise, T_CP);
                    chk(dram_addr == DAW'(cur_addr % (1 << COL_W)), "R9 column address", dram_addr, cur_addr % (1 << COL_W));
                    if (we_n == 0) begin
                        chk(p_we == 0, "R5 early write enable", p_we, 0);
                        chk(oe_n == 1 && dq_oe == 1, "R5 write bus state", {oe_n, dq_oe}, 3);
                        dev_mem[row_lat * (1 << COL_W) + int'(dram_addr)] = dq_out;
                    end else begin
                        chk(oe_n == 0, "R6 read output enable", oe_n, 0);
                        drv_data = dev_mem.exists(row_lat * (1 << COL_W) + int'(dram_addr)) ?
                                   dev_mem[row_lat * (1 << COL_W) + int'(dram_addr)] : '0;
                        drv_on = 1;
                    end
                end else begin
                    chk(since_ras_rise >= T_RP, "R7 precharge before refresh", since_ras_rise, T_RP);
                end
                since_cas_fall = 0;
            end
            if (p_cas == 0 && cas_n == 1) begin
                chk(since_cas_fall >= T_CAS, "R3 column low time", since_cas_fall, T_CAS);
                since_cas_rise = 0;
            end
            if (rsp_valid) begin
                responses++;
                if (exp_q.size() == 0) chk(0, "R10 unexpected response", rsp_rdata, 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata == e, "R6 read data", rsp_rdata, e);
                end
            end
            p_ras = ras_n; p_cas = cas_n; p_we = we_n;
        end
    end

    task automatic do_req(input bit we, input int addr, input int data);
        @(negedge clk);
        req_valid = 1; req_we = we; req_addr = AW'(addr); req_wdata = DW'(data);
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        cur_addr = addr;
        if (we) ref_mem[addr] = DW'(data);
        else exp_q.push_back(ref_mem.exists(addr) ? ref_mem[addr] : '0);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 200) begin @(negedge clk); guard++; end
        chk(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        int r0, f0, rise0, reads0, n_reads;
        repeat (3) @(negedge clk);
        // R1: state under reset
        chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 strobes idle in reset", {ras_n, cas_n, we_n, oe_n}, 15);
        chk(dq_oe == 0 && rsp_valid == 0, "R1 bus and response idle in reset", {dq_oe, rsp_valid}, 0);
        @(negedge clk); rst = 0;
        #1;
        chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 strobes idle after reset", {ras_n, cas_n, we_n, oe_n}, 15);
        chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
        run_model = 1;

        // R3: page hits - writes and reads in one row
        r0 = acc_ras_falls; f0 = refreshes;
        for (int c = 0; c < 8; c++) do_req(1, (5 << COL_W) | c, 16'h1000 + c * 7);
        for (int c = 7; c >= 0; c--) do_req(0, (5 << COL_W) | c, 0);
        drain();
        chk(acc_ras_falls - r0 <= 1 + (refreshes - f0), "R3 one row open per page", acc_ras_falls - r0, 1 + refreshes - f0);

        // R4: every request to a new row closes the open row
        r0 = acc_ras_falls; rise0 = ras_rises;
        for (int k = 0; k < 6; k++) do_req(k % 2, ((k + 7) << COL_W) | (k % 8), 16'hA500 + k);
        drain();
        chk(acc_ras_falls - r0 == 6, "R4 row opened per miss", acc_ras_falls - r0, 6);
        chk(ras_rises - rise0 >= 6, "R4 row closed per miss", ras_rises - rise0, 6);

        // R9: address corners
        do_req(1, (1 << AW) - 1, 16'hFFFE);
        do_req(1, 0, 16'h0001);
        do_req(0, (1 << AW) - 1, 0);
        do_req(0, 0, 0);
        drain();

        // R10: overwrite same word, then mixed traffic
        do_req(1, 9, 16'h1111);
        do_req(1, 9, 16'h2222);
        do_req(0, 9, 0);
        reads0 = responses; n_reads = 1;
        for (int k = 0; k < 120; k++) begin
            int a;
            a = (k * 37 + 11) % (1 << AW);
            if (k % 3 == 0) begin do_req(0, a, 0); n_reads++; end
            else do_req(1, a, k * 291 + 3);
        end
        drain();
        chk(responses - reads0 == n_reads, "R10 response count", responses - reads0, n_reads);

        // R8: idle period shows steady refresh
        f0 = refreshes;
        repeat (600) @(negedge clk);
        chk(refreshes - f0 >= 600 / REF_IV - 1, "R8 refresh rate", refreshes - f0, 600 / REF_IV - 1);
        chk(ras_n == 1 || cas_n == 0, "R8 idle row closed after refresh", ras_n, 1);

        finish_run();
    end
endmodule